// File: doc/BRIEF.md
# Extended Error Register Dump Sequencer

This block collects a unit's first-failure diagnostic state without software stepping through it. On a start strobe it latches the unit's base address. It reads an error-pointer register and follows the descriptor list that the pointer names. It then visits every diagnostic trace ring of the unit and drains each ring through a selector/mailbox register pair. Every register it reads for the dump leaves the block as a record holding the register address, an index word and the 64-bit value. An external FIFO takes these records.

All register traffic uses a simple bus. A request is a single-cycle `req_valid` with an address, plus write data when the request is a write. A response is a single-cycle `rsp_valid` with read data, and writes are acknowledged the same way. Only one request is in flight at any time. The block counts the records it emits and stops emitting once a parameterised limit is reached. The scan itself always runs to the end, and a one-cycle `done` marks the end of the scan.

Top module: `errdump_seq`

## Requirements
- R1: After start, the first bus request is a read of `base | PTR_OFS`. A value of 0 or all-ones skips the descriptor walk and goes straight to the ring scan.
- R2: Descriptor words are read at pointer `p`, then `p+8`, `p+16` and so on, where `p = base | pointer`. A word of 0 or all-ones ends the list. The descriptor fields are: target offset in bits 23:0 (ORed with base), length in bits 38:24, and mode in bit 39.
- R3: In repeat mode (bit 39 = 1) the target address is read `length` times. The records carry index 0 to length−1, and a length of 0 reads nothing.
- R4: In size mode (bit 39 = 0) the length is a byte count. `length/8` consecutive 8-byte registers are read, starting at the target, and each carries index 0. Any remainder bytes are ignored.
- R5: Rings 0 to NUM_RINGS−1 are scanned in ascending order. For each ring the block reads `base | (MAP_OFS + 8*ring)`, which holds the trap count in bits 31:24, the trace count in bits 23:16 and the entries per trace in bits 15:0. A map of 0 or all-ones skips the ring.
- R6: For trace t = 0..traces, the selector `(ring << 4) | t[3:0]` is first written to `base | SEL_OFS`. Then `base | MBX_OFS` is read `traps` times for t = 0, or `entries` times otherwise. Each record index is `(selector << 16) | entry`.
- R7: At most MAX_RECS records are emitted per scan. Later records are dropped while the scan continues. `rec_count` equals the number emitted.
- R8: A new request is never issued before the response to the previous one has arrived.
- R9: `done` is high for exactly one cycle at the end of the scan. `rec_count` holds its value until the next accepted start. A start while a scan is running is ignored.
- R10: After reset, `done`, `rec_valid` and `req_valid` are low and `rec_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| unit_base | input | AW | Unit base address, ORed into every address |
| req_valid | output | 1 | Bus request strobe |
| req_write | output | 1 | Request is a write |
| req_addr | output | AW | Request address |
| req_wdata | output | 64 | Write data (selector) |
| rsp_valid | input | 1 | Response / write acknowledge strobe |
| rsp_data | input | 64 | Read data |
| rec_valid | output | 1 | Record strobe toward the FIFO |
| rec_addr | output | AW | Record register address |
| rec_idx | output | 32 | Record index word |
| rec_val | output | 64 | Record value |
| rec_count | output | CW | Records emitted in this scan |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench builds the block with MAX_RECS set to 12 and keeps the defaults for eight rings, the 4+4 bit selector and the register offsets. The small limit means a single 20-entry repeat descriptor followed by a populated ring crosses the cap, so dropping and count saturation are exercised with a short list. The register model returns address-derived data, and mailbox words that encode the current selector and read position. A wrong address, index, ordering or selector therefore shows up directly in the scoreboard comparison.

// File: rtl/errdump_pkg.sv
package errdump_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_DESC,
        ST_DATA,
        ST_MAP,
        ST_SEL,
        ST_MBX,
        ST_DONE
    } seq_st_e;

    localparam int unsigned DLEN_W = 15;
    localparam int unsigned ENT_W  = 16;
    localparam int unsigned IDX_W  = 32;

endpackage

// File: rtl/errdump_fields.sv
module errdump_fields
    import errdump_pkg::*;
(
    input  logic [63:0]       word,
    output logic              blank,
    output logic [23:0]       d_offs,
    output logic [DLEN_W-1:0] d_len,
    output logic              d_rep,
    output logic [7:0]        m_traps,
    output logic [7:0]        m_traces,
    output logic [ENT_W-1:0]  m_ents
);
    always_comb begin
        blank    = (word == 64'h0) || (&word);
        d_offs   = word[23:0];
        d_len    = word[38:24];
        d_rep    = word[39];
        m_traps  = word[31:24];
        m_traces = word[23:16];
        m_ents   = word[15:0];
    end
endmodule

// File: rtl/errdump_rec_gate.sv
module errdump_rec_gate
    import errdump_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned MAX_RECS = 256,
    localparam int unsigned CW      = $clog2(MAX_RECS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_valid,
    input  logic [AW-1:0]    in_addr,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [63:0]      in_val,
    output logic             out_valid,
    output logic [AW-1:0]    out_addr,
    output logic [IDX_W-1:0] out_idx,
    output logic [63:0]      out_val,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [IDX_W-1:0] idx;
        logic [63:0]      val;
        logic [CW-1:0]    cnt;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.vld = 1'b0;
        if (clear) begin
            g_d.cnt = '0;
        end else if (in_valid && (g_q.cnt < CW'(MAX_RECS))) begin
            g_d.vld  = 1'b1;
            g_d.addr = in_addr;
            g_d.idx  = in_idx;
            g_d.val  = in_val;
            g_d.cnt  = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign out_valid = g_q.vld;
    assign out_addr  = g_q.addr;
    assign out_idx   = g_q.idx;
    assign out_val   = g_q.val;
    assign count     = g_q.cnt;
endmodule

// File: rtl/errdump_seq.sv
module errdump_seq
    import errdump_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned MAX_RECS    = 256,
    parameter int unsigned NUM_RINGS   = 8,
    parameter int unsigned SEL_RING_W  = 4,
    parameter int unsigned SEL_TRACE_W = 4,
    parameter int unsigned PTR_OFS     = 32'h10,
    parameter int unsigned SEL_OFS     = 32'h20,
    parameter int unsigned MBX_OFS     = 32'h28,
    parameter int unsigned MAP_OFS     = 32'h100,
    localparam int unsigned CW         = $clog2(MAX_RECS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] unit_base,
    output logic          req_valid,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [63:0]   req_wdata,
    input  logic          rsp_valid,
    input  logic [63:0]   rsp_data,
    output logic          rec_valid,
    output logic [AW-1:0] rec_addr,
    output logic [31:0]   rec_idx,
    output logic [63:0]   rec_val,
    output logic [CW-1:0] rec_count,
    output logic          done
);
    localparam int unsigned RW    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;
    localparam int unsigned SEL_W = SEL_RING_W + SEL_TRACE_W;

    typedef struct packed {
        seq_st_e           st;
        logic              pend;
        logic [AW-1:0]     base;
        logic [AW-1:0]     lptr;
        logic [AW-1:0]     daddr;
        logic              drep;
        logic [DLEN_W-1:0] dlen;
        logic [DLEN_W-1:0] iter;
        logic [RW-1:0]     ring;
        logic [7:0]        traps;
        logic [7:0]        traces;
        logic [ENT_W-1:0]  ents;
        logic [7:0]        trace;
        logic [ENT_W-1:0]  entry;
    } seq_t;

    seq_t s_d, s_q;

    logic              f_blank, f_rep;
    logic [23:0]       f_offs;
    logic [DLEN_W-1:0] f_len, f_cnt;
    logic [7:0]        f_traps, f_traces;
    logic [ENT_W-1:0]  f_ents;

    errdump_fields u_fields (
        .word     (rsp_data),
        .blank    (f_blank),
        .d_offs   (f_offs),
        .d_len    (f_len),
        .d_rep    (f_rep),
        .m_traps  (f_traps),
        .m_traces (f_traces),
        .m_ents   (f_ents)
    );

    assign f_cnt = f_rep ? f_len : (f_len >> 3);

    logic             accept, bus_st, go_trace, go_ring, clr;
    logic             g_valid;
    logic [AW-1:0]    g_addr;
    logic [IDX_W-1:0] g_idx;
    logic [SEL_W-1:0] sel;
    logic [ENT_W-1:0] cur_n;

    assign sel   = {SEL_RING_W'(s_q.ring), s_q.trace[SEL_TRACE_W-1:0]};
    assign cur_n = (s_q.trace == 8'd0) ? ENT_W'(s_q.traps) : s_q.ents;

    always_comb begin
        s_d       = s_q;
        clr       = 1'b0;
        g_valid   = 1'b0;
        g_addr    = '0;
        g_idx     = '0;
        go_trace  = 1'b0;
        go_ring   = 1'b0;
        done      = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        bus_st    = 1'b1;

        unique case (s_q.st)
            ST_PTR:  req_addr = s_q.base | AW'(PTR_OFS);
            ST_DESC: req_addr = s_q.lptr;
            ST_DATA: req_addr = s_q.daddr;
            ST_MAP:  req_addr = s_q.base | (AW'(MAP_OFS) + (AW'(s_q.ring) << 3));
            ST_SEL: begin
                req_addr  = s_q.base | AW'(SEL_OFS);
                req_write = 1'b1;
                req_wdata = 64'(sel);
            end
            ST_MBX:  req_addr = s_q.base | AW'(MBX_OFS);
            default: begin
                req_addr = '0;
                bus_st   = 1'b0;
            end
        endcase

        req_valid = bus_st && !s_q.pend;
        if (req_valid) s_d.pend = 1'b1;
        accept = s_q.pend && rsp_valid;
        if (accept) s_d.pend = 1'b0;

        unique case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.st   = ST_PTR;
                s_d.base = unit_base;
                clr      = 1'b1;
            end
            ST_PTR: if (accept) begin
                if (f_blank) begin
                    s_d.st   = ST_MAP;
                    s_d.ring = '0;
                end else begin
                    s_d.lptr = s_q.base | rsp_data[AW-1:0];
                    s_d.st   = ST_DESC;
                end
            end
            ST_DESC: if (accept) begin
                if (f_blank) begin
                    s_d.st   = ST_MAP;
                    s_d.ring = '0;
                end else begin
                    s_d.daddr = s_q.base | AW'(f_offs);
                    s_d.drep  = f_rep;
                    s_d.dlen  = f_cnt;
                    s_d.iter  = '0;
                    if (f_cnt == '0) s_d.lptr = s_q.lptr + AW'(8);
                    else             s_d.st   = ST_DATA;
                end
            end
            ST_DATA: if (accept) begin
                g_valid  = 1'b1;
                g_addr   = s_q.daddr;
                g_idx    = s_q.drep ? IDX_W'(s_q.iter) : '0;
                s_d.iter = s_q.iter + 1'b1;
                if (!s_q.drep) s_d.daddr = s_q.daddr + AW'(8);
                if (s_q.iter + 1'b1 == s_q.dlen) begin
                    s_d.lptr = s_q.lptr + AW'(8);
                    s_d.st   = ST_DESC;
                end
            end
            ST_MAP: if (accept) begin
                if (f_blank) begin
                    go_ring = 1'b1;
                end else begin
                    s_d.traps  = f_traps;
                    s_d.traces = f_traces;
                    s_d.ents   = f_ents;
                    s_d.trace  = '0;
                    s_d.st     = ST_SEL;
                end
            end
            ST_SEL: if (accept) begin
                s_d.entry = '0;
                if (cur_n == '0) go_trace = 1'b1;
                else             s_d.st   = ST_MBX;
            end
            ST_MBX: if (accept) begin
                g_valid   = 1'b1;
                g_addr    = s_q.base | AW'(MBX_OFS);
                g_idx     = IDX_W'({sel, s_q.entry});
                s_d.entry = s_q.entry + 1'b1;
                if (s_q.entry + 1'b1 == cur_n) go_trace = 1'b1;
            end
            ST_DONE: begin
                done   = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (go_trace) begin
            if (s_q.trace == s_q.traces) begin
                go_ring = 1'b1;
            end else begin
                s_d.trace = s_q.trace + 1'b1;
                s_d.st    = ST_SEL;
            end
        end
        if (go_ring) begin
            if (s_q.ring == RW'(NUM_RINGS - 1)) begin
                s_d.st = ST_DONE;
            end else begin
                s_d.ring = s_q.ring + 1'b1;
                s_d.st   = ST_MAP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    errdump_rec_gate #(.AW(AW), .MAX_RECS(MAX_RECS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .in_valid  (g_valid),
        .in_addr   (g_addr),
        .in_idx    (g_idx),
        .in_val    (rsp_data),
        .out_valid (rec_valid),
        .out_addr  (rec_addr),
        .out_idx   (rec_idx),
        .out_val   (rec_val),
        .count     (rec_count)
    );
endmodule

// File: rtl/errdump_seq_chk.sv
module errdump_seq_chk #(
    parameter int unsigned MAX_RECS = 256,
    parameter int unsigned SEL_W    = 8,
    localparam int unsigned CW      = $clog2(MAX_RECS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [63:0]   req_wdata,
    input logic          rec_valid,
    input logic [CW-1:0] rec_count,
    input logic          done
);
    a_r8_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count <= CW'(MAX_RECS));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_count == $past(rec_count) + 1'b1);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    a_r6_sel_width: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_wdata >> SEL_W) == 64'h0);
endmodule

bind errdump_seq errdump_seq_chk #(
    .MAX_RECS (MAX_RECS),
    .SEL_W    (SEL_RING_W + SEL_TRACE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rec_valid (rec_valid),
    .rec_count (rec_count),
    .done      (done)
);

// File: tb/test_errdump_seq.sv
module test_errdump_seq;
    localparam int CLK_NS = 10;
    localparam int AW     = 32;
    localparam int MAXR   = 12;
    localparam int CW     = $clog2(MAXR + 1);
    localparam logic [31:0] PTR = 32'h10, SEL = 32'h20, MBX = 32'h28, MAP = 32'h100;

    logic clk = 0, rst_n = 0, start = 0;
    logic [AW-1:0] unit_base = '0;
    logic req_valid, req_write, rec_valid, done;
    logic [AW-1:0] req_addr, rec_addr;
    logic [63:0] req_wdata, rec_val;
    logic rsp_valid = 0;
    logic [63:0] rsp_data = '0;
    logic [31:0] rec_idx;
    logic [CW-1:0] rec_count;

    errdump_seq #(.AW(AW), .MAX_RECS(MAXR)) i_errdump_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .unit_base(unit_base),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_idx(rec_idx),
        .rec_val(rec_val), .rec_count(rec_count), .done(done)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct { logic [31:0] a; logic [31:0] i; logic [63:0] v; } rec_t;
    rec_t expq[$];
    logic [63:0] regs [logic [31:0]];
    int total = 0, bad = 0, pushed = 0, done_seen = 0;
    logic [31:0] cur_base = '0;
    logic [7:0] cur_sel = '0;
    int mbx_cnt = 0;
    bit first_req = 0, pending = 0;
    logic [63:0] pdata = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a);
        if (regs.exists(a)) return regs[a];
        if (a[15:12] == 4'h1) return {~a, a};
        return 64'h0;
    endfunction

    function automatic bit blank(input logic [63:0] w);
        return (w == 64'h0) || (&w);
    endfunction

    function automatic logic [63:0] mbx_word(input logic [7:0] s, input int k);
        return {16'hB0B0, 8'h00, s, 16'h0000, 16'(k)};
    endfunction

    task automatic push(input logic [31:0] a, input logic [31:0] i, input logic [63:0] v);
        rec_t r;
        r.a = a; r.i = i; r.v = v;
        if (pushed < MAXR) expq.push_back(r);   // R7 limit
        pushed++;
    endtask

    // Expected record stream built from R1..R6
    task automatic build_expect(input logic [31:0] b);
        logic [63:0] p, e, m;
        logic [31:0] l, ta;
        int len;
        pushed = 0;
        p = model(b | PTR);
        if (!blank(p)) begin
            l = b | p[31:0];
            forever begin
                e = model(l);
                if (blank(e)) break;
                ta  = b | {8'h0, e[23:0]};
                len = int'(e[38:24]);
                if (e[39]) begin
                    for (int i = 0; i < len; i++) push(ta, 32'(i), model(ta));
                end else begin
                    for (int i = 0; i < len / 8; i++) push(ta + 32'(8*i), 0, model(ta + 32'(8*i)));
                end
                l = l + 8;
            end
        end
        for (int r = 0; r < 8; r++) begin
            m = model(b | (MAP + 32'(8*r)));
            if (blank(m)) continue;
            for (int t = 0; t <= int'(m[23:16]); t++) begin
                logic [7:0] s;
                int n;
                s = {4'(r), 4'(t)};
                n = (t == 0) ? int'(m[31:24]) : int'(m[15:0]);
                for (int k = 0; k < n; k++) push(b | MBX, {8'h0, s, 16'(k)}, mbx_word(s, k));
            end
        end
    endtask

    // Bus responder: one cycle latency, flags overlapping requests (R8)
    initial begin
        forever begin
            bit was;
            @(negedge clk);
            was = pending;
            rsp_valid = 0;
            if (was) begin
                rsp_valid = 1;
                rsp_data  = pdata;
                pending   = 0;
            end
            if (req_valid) begin
                if (was) chk(0, "R8", "request while one is outstanding", 1, 0);
                if (first_req) begin
                    chk(req_addr == (cur_base | PTR) && !req_write, "R1", "first request address",
                        64'(req_addr), 64'(cur_base | PTR));
                    first_req = 0;
                end
                if (req_write) begin
                    chk(req_addr == (cur_base | SEL), "R6", "selector write address",
                        64'(req_addr), 64'(cur_base | SEL));
                    cur_sel = req_wdata[7:0];
                    mbx_cnt = 0;
                    pdata   = 64'h0;
                end else if (req_addr == (cur_base | MBX)) begin
                    pdata = mbx_word(cur_sel, mbx_cnt);
                    mbx_cnt++;
                end else begin
                    pdata = model(req_addr);
                end
                pending = 1;
            end
        end
    end

    // Monitor: pops expected records as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (rec_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R7", "unexpected extra record", 64'(rec_idx), 0);
                end else begin
                    rec_t r;
                    r = expq.pop_front();
                    chk(rec_addr == r.a && rec_idx == r.i && rec_val == r.v, "R2-R6",
                        "record addr/idx", {rec_addr, rec_idx}, {r.a, r.i});
                end
            end
            if (done) done_seen++;
        end
    end

    task automatic run(input logic [31:0] b, input bit poke_busy, input string tag);
        int cyc;
        int exp_cnt;
        logic [CW-1:0] held;
        build_expect(b);
        exp_cnt = (pushed < MAXR) ? pushed : MAXR;
        @(negedge clk);
        cur_base  = b;
        first_req = 1;
        unit_base = b;
        start     = 1;
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke_busy && cyc == 30) begin
                unit_base = b ^ 32'h0100_0000;
                start = 1;                  // R9: ignored while busy
            end else begin
                start = 0;
            end
        end
        chk(done === 1'b1, "R9", {tag, " done reached"}, 64'(done), 1);
        chk(expq.size() == 0, "R7", {tag, " all expected records seen"}, 64'(expq.size()), 0);
        chk(rec_count == CW'(exp_cnt), "R7", {tag, " record count"}, 64'(rec_count), 64'(exp_cnt));
        held = rec_count;
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done is one cycle"}, 64'(done), 0);
        repeat (5) @(negedge clk);
        chk(rec_count == held && !req_valid, "R9", {tag, " count held when idle"},
            64'(rec_count), 64'(held));
        expq.delete();
    endtask

    initial begin
        #(CLK_NS * 150000);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0, "R10", "done after reset", 64'(done), 0);
        chk(rec_valid == 0, "R10", "rec_valid after reset", 64'(rec_valid), 0);
        chk(req_valid == 0, "R10", "req_valid after reset", 64'(req_valid), 0);
        chk(rec_count == 0, "R10", "count after reset", 64'(rec_count), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // A: null pointer, rings only (R1, R5, R6)
        regs.delete();
        regs[32'h0200_0000 | MAP + 8]  = 64'h0201_0003;
        regs[32'h0200_0000 | MAP + 24] = 64'hFFFF_FFFF_FFFF_FFFF;
        regs[32'h0200_0000 | MAP + 40] = 64'h0002_0001;
        run(32'h0200_0000, 0, "A");

        // B: descriptor list, both modes, zero-length cases, busy start (R2, R3, R4, R9)
        regs.delete();
        regs[32'h0400_0000 | PTR]   = 64'h800;
        regs[32'h0400_0800]         = (64'h1 << 39) | (64'd3 << 24) | 64'h1100;
        regs[32'h0400_0808]         = (64'd7 << 24) | 64'h1200;
        regs[32'h0400_0810]         = (64'd16 << 24) | 64'h1300;
        regs[32'h0400_0818]         = (64'h1 << 39) | 64'h1400;
        regs[32'h0400_0000 | MAP]   = 64'h0100_0000;
        run(32'h0400_0000, 1, "B");

        // C: all-ones pointer skips the walk (R1), last ring only (R5)
        regs.delete();
        regs[32'h0600_0000 | PTR]      = 64'hFFFF_FFFF_FFFF_FFFF;
        regs[32'h0600_0800]            = (64'h1 << 39) | (64'd2 << 24) | 64'h1100;
        regs[32'h0600_0000 | MAP + 56] = 64'h0300_0000;
        run(32'h0600_0000, 0, "C");

        // D: overflow past MAXR, all-ones list terminator (R7, R2)
        regs.delete();
        regs[32'h0800_0000 | PTR]      = 64'h800;
        regs[32'h0800_0800]            = (64'h1 << 39) | (64'd20 << 24) | 64'h1500;
        regs[32'h0800_0808]            = 64'hFFFF_FFFF_FFFF_FFFF;
        regs[32'h0800_0000 | MAP + 16] = 64'h0201_0002;
        run(32'h0800_0000, 0, "D");

        // E: rerun A, count restarts from zero (R9)
        regs.delete();
        regs[32'h0200_0000 | MAP + 8]  = 64'h0201_0003;
        regs[32'h0200_0000 | MAP + 40] = 64'h0002_0001;
        run(32'h0200_0000, 0, "E");

        chk(done_seen == 5, "R9", "one done per accepted start", 64'(done_seen), 5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule